// File: doc/BRIEF.md
# Buffered SPI Target Interface

This block is an SPI target that moves bytes between a serial host and two circular byte stores: one that collects what the host shifts in, and one that software preloads with what the host will shift out. A single byte pointer indexes both stores, so byte k of a transaction lands in input slot k and is answered from output slot k in full-duplex fashion. The pointer wraps at the store depth, or, with wrapping turned off, parks on the last slot and drops further input.

The serial pins are brought into the system clock domain through a two-stage synchronizer, so SCLK must run at no more than one eighth of the system clock. Software reaches configuration, event enables, event status, the pointer and both stores through a flat register port. Events mark the pointer reaching the half mark, completing the last slot, dropping a byte and the release of chip select. The interrupt output combines each status bit with its enable bit.

Top module: `spi_buf_target`

## Requirements
- R1: After reset the configuration, event enable and event status registers read 0, the pointer reads 0, the interrupt is low and MISO is high.
- R2: Byte k of a transaction (MSB first, sampled on the active SCLK edge) is stored at input slot k mod 64 when wrapping is on (configuration bit 7).
- R3: MISO carries output slot k mod 64 for byte k, MSB first, changing on the inactive SCLK edge; it is held high while chip select (active low) is high or the block is disabled.
- R4: Chip select assertion leaves the pointer unchanged; the pointer clears on the 7th active SCLK edge of the transaction and then advances by one per completed byte.
- R5: With wrapping off, the pointer stays at 63 after the 64th byte; later bytes are not stored and each sets the overrun status bit (bit 7).
- R6: Status bit 3 is set when the pointer advances to 32; status bit 2 is set when the byte at slot 63 completes.
- R7: Status bit 4 is set when chip select is released, whatever the number of bits clocked.
- R8: Writing ones to the status register clears those bits only; the interrupt is high exactly when some status bit and the same enable bit are both 1.
- R9: With configuration bit 2 (store enable) at 0, received bytes are not written to the input store, while the pointer still advances.
- R10: With configuration bit 0 (module enable) at 0, bus activity changes neither the pointer nor the status, and MISO stays high.
- R11: With configuration bit 6 set, SCLK idles high and the active edge is the falling pin edge; data transfer otherwise follows R2 and R3.
- R12: Register port map: address bits [7:6] select 00 control (offset 0 configuration, 1 event enable, 2 event status, 3 pointer), 01 input store read, 10 output store read/write; bits [5:0] index the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| reg_addr_i | input | 8 | Register port address |
| reg_we_i | input | 1 | Register port write strobe |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block at its default depth of 64 slots with the pointer clear on the 7th edge, and runs SCLK at one sixteenth of the system clock. With that depth a 100-byte full-duplex transfer crosses the half mark twice and the last slot once, so the wrap, the overwrite of the low 36 slots and the order of the half, full and release events all come within reach, and a 70-byte transfer with wrapping off reaches the parked pointer and the dropped bytes. A transaction stopped after 6, 7 and 8 edges exposes the delayed pointer clear.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int CFG_WRAP = 7;
  localparam int CFG_CPOL = 6;
  localparam int CFG_WEN  = 2;
  localparam int CFG_EN   = 0;

  localparam int EV_OVR  = 7;
  localparam int EV_EOR  = 4;
  localparam int EV_HALF = 3;
  localparam int EV_FULL = 2;

  typedef enum logic [1:0] {
    SPACE_CTRL = 2'b00,
    SPACE_IBUF = 2'b01,
    SPACE_OBUF = 2'b10,
    SPACE_NONE = 2'b11
  } space_e;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_EVEN = 2'd1;
  localparam logic [1:0] REG_EVST = 2'd2;
  localparam logic [1:0] REG_PTR  = 2'd3;
endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbt_shifter.sv
module sbt_shifter #(
  parameter int RST_EDGE = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cs_n_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       tx_first_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       ptr_rst_o,
  output logic       cs_rise_o
);
  logic       sclk_q, cs_q, first_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_sh_q;
  logic [7:0] tx_sh_q;

  wire active = en_i & ~cs_n_i;
  wire rise   = active & sclk_i & ~sclk_q;
  wire fall   = active & ~sclk_i & sclk_q;
  wire cs_fall = en_i & cs_q & ~cs_n_i;
  wire cs_rise = en_i & ~cs_q & cs_n_i;

  assign tx_first_o = cs_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      first_q     <= 1'b0;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      miso_o      <= 1'b1;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
      ptr_rst_o   <= 1'b0;
      cs_rise_o   <= 1'b0;
    end else begin
      sclk_q      <= sclk_i;
      cs_q        <= cs_n_i;
      byte_done_o <= 1'b0;
      ptr_rst_o   <= 1'b0;
      cs_rise_o   <= cs_rise;
      if (cs_fall) begin
        bit_cnt_q <= '0;
        first_q   <= 1'b1;
        miso_o    <= tx_byte_i[7];
        tx_sh_q   <= {tx_byte_i[6:0], 1'b0};
      end else if (!active) begin
        bit_cnt_q <= '0;
        miso_o    <= 1'b1;
      end else begin
        if (rise) begin
          rx_sh_q   <= {rx_sh_q[5:0], mosi_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (first_q && bit_cnt_q == 3'(RST_EDGE - 1)) ptr_rst_o <= 1'b1;
          if (bit_cnt_q == 3'd7) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sh_q, mosi_i};
            first_q     <= 1'b0;
          end
        end
        if (fall) begin
          if (bit_cnt_q == 3'd0) begin
            miso_o  <= tx_byte_i[7];
            tx_sh_q <= {tx_byte_i[6:0], 1'b0};
          end else begin
            miso_o  <= tx_sh_q[7];
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> miso_o); // R3
  AST_ONE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_o |-> !byte_done_o); // R4
endmodule

// File: rtl/sbt_events.sv
module sbt_events #(
  parameter int NEV = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic           en_we_i,
  input  logic           st_we_i,
  input  logic [NEV-1:0] wdata_i,
  output logic [NEV-1:0] en_o,
  output logic [NEV-1:0] st_o,
  output logic           irq_o
);
  wire [NEV-1:0] clr = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= '0;
      st_o <= '0;
    end else begin
      if (en_we_i) en_o <= wdata_i;
      st_o <= (st_o & ~clr) | set_i;  // a new event wins over a clear
    end
  end

  assign irq_o = |(st_o & en_o);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && set_i == '0) |=> (st_o & $past(wdata_i)) == '0); // R8
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (st_o & $past(set_i)) == $past(set_i)); // R6
endmodule

// File: rtl/spi_buf_target.sv
module spi_buf_target #(
  parameter int DEPTH    = 64,
  parameter int RST_EDGE = 7,
  parameter int SYNC_STAGES = 2,
  localparam int PW      = $clog2(DEPTH),
  localparam int AW      = PW + 2,
  localparam int HALF    = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          irq_o
);
  import sbt_pkg::*;

  localparam logic [PW-1:0] PTR_MAX  = PW'(DEPTH - 1);
  localparam logic [PW-1:0] PTR_HALF = PW'(HALF - 1);

  logic [7:0]    cfg_q;
  logic [PW-1:0] ptr_q;
  logic          full_q;
  logic [7:0]    ibuf [DEPTH];
  logic [7:0]    obuf [DEPTH];

  logic       cs_s, sclk_s, mosi_s;
  logic       tx_first, byte_done, ptr_rst, cs_rise;
  logic [7:0] rx_byte, tx_byte;
  logic [7:0] ev_set, ev_en, ev_st;

  sbt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sclk_i, mosi_i}),
    .q_o ({cs_s, sclk_s, mosi_s})
  );

  assign tx_byte = tx_first ? obuf[0] : obuf[ptr_q];

  sbt_shifter #(.RST_EDGE(RST_EDGE)) u_shifter (
    .clk_i, .rst_ni,
    .en_i        (cfg_q[CFG_EN]),
    .cs_n_i      (cs_s),
    .sclk_i      (sclk_s ^ cfg_q[CFG_CPOL]),
    .mosi_i      (mosi_s),
    .tx_byte_i   (tx_byte),
    .miso_o      (miso_o),
    .tx_first_o  (tx_first),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .ptr_rst_o   (ptr_rst),
    .cs_rise_o   (cs_rise)
  );

  space_e     space;
  logic [1:0] reg_sel;
  logic [PW-1:0] idx;
  assign space   = space_e'(reg_addr_i[AW-1 -: 2]);
  assign reg_sel = reg_addr_i[1:0];
  assign idx     = reg_addr_i[PW-1:0];

  wire ctrl_we = reg_we_i && space == SPACE_CTRL;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_OVR]  = byte_done & full_q;
    ev_set[EV_HALF] = byte_done & ~full_q & (ptr_q == PTR_HALF);
    ev_set[EV_FULL] = byte_done & ~full_q & (ptr_q == PTR_MAX);
    ev_set[EV_EOR]  = cs_rise;
  end

  sbt_events #(.NEV(8)) u_events (
    .clk_i, .rst_ni,
    .set_i   (ev_set),
    .en_we_i (ctrl_we && reg_sel == REG_EVEN),
    .st_we_i (ctrl_we && reg_sel == REG_EVST),
    .wdata_i (reg_wdata_i),
    .en_o    (ev_en),
    .st_o    (ev_st),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (ctrl_we && reg_sel == REG_CFG) cfg_q <= reg_wdata_i;
      if (ptr_rst) begin
        ptr_q  <= '0;
        full_q <= 1'b0;
      end else if (byte_done && !full_q) begin
        if (ptr_q == PTR_MAX) begin
          if (cfg_q[CFG_WRAP]) ptr_q <= '0;
          else full_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_done && !full_q && cfg_q[CFG_WEN]) ibuf[ptr_q] <= rx_byte;
    if (reg_we_i && space == SPACE_OBUF) obuf[idx] <= reg_wdata_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (space)
      SPACE_CTRL: begin
        unique case (reg_sel)
          REG_CFG:  reg_rdata_o = cfg_q;
          REG_EVEN: reg_rdata_o = ev_en;
          REG_EVST: reg_rdata_o = ev_st;
          default:  reg_rdata_o = 8'(ptr_q);
        endcase
      end
      SPACE_IBUF: reg_rdata_o = ibuf[idx];
      SPACE_OBUF: reg_rdata_o = obuf[idx];
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == '0 || ptr_q == PW'($past(ptr_q) + 1'b1))); // R4
  AST_PARKED_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> ptr_q == PTR_MAX); // R5
  AST_DISABLED_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[CFG_EN] && !$past(cfg_q[CFG_EN]) && !$past(cfg_q[CFG_EN], 2)) |=> $stable(ptr_q)); // R10
  AST_EOR_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> ev_st[EV_EOR]); // R7
endmodule

// File: tb/spi_buf_target_tb.sv
module spi_buf_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int DEPTH      = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_buf_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] got [0:127];
  logic mon = 1'b0;
  int t_half, t_full, t_eor;

  function automatic logic [7:0] ob(int i); return 8'(i * 29 + 7); endfunction
  function automatic logic [7:0] mo(int k, int s); return 8'(k * 37 + s); endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<200000", cyc);
      summary();
    end
  end

  always @(negedge clk) if (mon) begin
    if (reg_rdata[3] && t_half < 0) t_half = cyc;
    if (reg_rdata[2] && t_full < 0) t_full = cyc;
    if (reg_rdata[4] && t_eor  < 0) t_eor  = cyc;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic bits(int n, int seed, logic cpol, int base);
    for (int b = 0; b < n; b++) begin
      int k, pos;
      k = (base + b) / 8; pos = 7 - (base + b) % 8;
      mosi = mo(k, seed)[pos];
      repeat (HALF_SCK) @(negedge clk);
      sclk = ~cpol;
      got[k][pos] = miso;
      repeat (HALF_SCK) @(negedge clk);
      sclk = cpol;
    end
  endtask

  task automatic cs_lo(); @(negedge clk); cs_n = 1'b0; repeat (HALF_SCK) @(negedge clk); endtask
  task automatic cs_hi(); repeat (HALF_SCK) @(negedge clk); cs_n = 1'b1; repeat (10) @(negedge clk); endtask

  task automatic xfer(int nbytes, int seed, logic cpol);
    cs_lo(); bits(nbytes * 8, seed, cpol, 0); cs_hi();
  endtask

  initial begin
    logic [7:0] d;
    int err;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1 cfg", d, 0);
    rd(8'h01, d); chk(d == 0, "R1 enable", d, 0);
    rd(8'h02, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h03, d); chk(d == 0, "R1 ptr", d, 0);
    chk(irq == 0 && miso == 1, "R1 irq/miso", {irq, miso}, 1);

    // R12 output store write/readback
    for (int i = 0; i < DEPTH; i++) wr(8'h80 | 8'(i), ob(i));
    err = 0;
    for (int i = 0; i < DEPTH; i++) begin rd(8'h80 | 8'(i), d); if (d != ob(i)) err++; end
    chk(err == 0, "R12 obuf readback", err, 0);

    wr(8'h00, 8'h85);
    wr(8'h01, 8'h9C);
    // 100-byte full-duplex transfer
    rd(8'h02, d);
    t_half = -1; t_full = -1; t_eor = -1; mon = 1'b1;
    xfer(100, 11, 1'b0);
    mon = 1'b0;
    err = 0;
    for (int k = 0; k < 100; k++) if (got[k] != ob(k % DEPTH)) err++;
    chk(err == 0, "R3 miso bytes", err, 0);
    err = 0;
    for (int j = 0; j < DEPTH; j++) begin
      rd(8'h40 | 8'(j), d);
      if (d != mo(j < 36 ? j + 64 : j, 11)) err++;
    end
    chk(err == 0, "R2 ibuf wrap contents", err, 0);
    rd(8'h03, d); chk(d == 36, "R4 ptr after 100", d, 36);
    chk(t_half >= 0 && t_full > t_half, "R6 half before full", t_full, t_half);
    chk(t_eor > t_full, "R7 eor last", t_eor, t_full);
    rd(8'h02, d); chk(d == 8'h1C, "R6 status", d, 8'h1C);
    chk(irq == 1, "R8 irq set", irq, 1);
    wr(8'h02, 8'h04);
    rd(8'h02, d); chk(d == 8'h18, "R8 w1c partial", d, 8'h18);
    wr(8'h01, 8'h80);
    chk(irq == 0, "R8 irq masked", irq, 0);
    wr(8'h01, 8'h08);
    chk(irq == 1, "R8 irq unmasked", irq, 1);
    wr(8'h02, 8'hFF);
    rd(8'h02, d); chk(d == 0 && irq == 0, "R8 w1c all", d, 0);

    // R4 delayed pointer clear
    cs_lo();
    rd(8'h03, d); chk(d == 36, "R4 ptr kept at cs", d, 36);
    bits(6, 50, 1'b0, 0);
    rd(8'h03, d); chk(d == 36, "R4 ptr after 6 edges", d, 36);
    bits(1, 50, 1'b0, 6);
    rd(8'h03, d); chk(d == 0, "R4 ptr after 7 edges", d, 0);
    bits(1, 50, 1'b0, 7);
    rd(8'h03, d); chk(d == 1, "R4 ptr after byte", d, 1);
    cs_hi();
    rd(8'h02, d); chk(d == 8'h10, "R7 eor short xfer", d, 8'h10);
    wr(8'h02, 8'hFF);

    // R5 no wrap
    wr(8'h00, 8'h05);
    xfer(70, 23, 1'b0);
    rd(8'h03, d); chk(d == 63, "R5 ptr parked", d, 63);
    rd(8'h02, d); chk(d == 8'h9C, "R5 overrun status", d, 8'h9C);
    err = 0;
    for (int j = 0; j < DEPTH; j++) begin rd(8'h40 | 8'(j), d); if (d != mo(j, 23)) err++; end
    chk(err == 0, "R5 dropped bytes", err, 0);
    wr(8'h02, 8'hFF);

    // R9 store disabled
    wr(8'h00, 8'h81);
    xfer(4, 99, 1'b0);
    err = 0;
    for (int j = 0; j < 4; j++) begin rd(8'h40 | 8'(j), d); if (d != mo(j, 23)) err++; end
    chk(err == 0, "R9 ibuf untouched", err, 0);
    rd(8'h03, d); chk(d == 4, "R9 ptr advances", d, 4);
    wr(8'h02, 8'hFF);

    // R10 module disabled
    wr(8'h00, 8'h00);
    xfer(3, 77, 1'b0);
    err = 0;
    for (int k = 0; k < 3; k++) if (got[k] != 8'hFF) err++;
    chk(err == 0, "R10 miso high", err, 0);
    rd(8'h03, d); chk(d == 4, "R10 ptr still", d, 4);
    rd(8'h02, d); chk(d == 0, "R10 no events", d, 0);

    // R11 inverted clock polarity
    wr(8'h00, 8'hC5);
    @(negedge clk); sclk = 1'b1;
    repeat (5) @(negedge clk);
    xfer(4, 200, 1'b1);
    err = 0;
    for (int j = 0; j < 4; j++) begin
      rd(8'h40 | 8'(j), d);
      if (d != mo(j, 200) || got[j] != ob(j)) err++;
    end
    chk(err == 0, "R11 cpol transfer", err, 0);
    rd(8'h03, d); chk(d == 4, "R11 ptr", d, 4);

    summary();
  end
endmodule